// File: doc/BRIEF.md
# Round-Robin Interrupt Pending Selector

This block sits between a set of internal interrupt sources and two processor cores. Each core owns a bank of enable bits. A source counts as pending for a core when its raw status line and that core's enable bit are both high. Each core has its own arbiter, which picks one pending source by rotation, so no source has a fixed priority over another. The arbiter presents the pick on a request line with a source ID and holds it until the core acknowledges.

Software changes the enable banks through a one-operation-per-cycle command port. A disable operation clears one source in the bank of every core that is present. An enable operation decides per core from the core's online flag and an optional affinity set. A read port returns one 32-bit enable word and the matching masked-status word. Enable words are kept with the word order reversed.

A configurable contiguous window of sources can be marked as cascaded external lines. A source inside that window is reported with an offset-from-window ID and an external tag.

Top module: `rr_irq_selector`

## Requirements
- R1: A source is pending for a core only when its `src_status` bit and that core's enable bit are both 1. A source with either bit at 0 is never selected, and a request only rises for a core that has at least one pending source.
- R2: Selection scans upward starting at the core's rotation pointer, and the first pending source found is chosen. After an acknowledge, the pointer becomes the granted source index plus one.
- R3: The rotation pointer and the scan both wrap modulo `NUM_SRC`. After the highest pending source is granted, the lowest pending source comes next.
- R4: Each core has its own rotation pointer and its own request state. A grant to one core does not move the other core's pointer.
- R5: While a core has no pending source, its `irq_req` stays 0, its ID and external outputs are 0, and its pointer is not changed.
- R6: Source n's enable bit sits in physical word (n/32) XOR (WORDS-1), at bit n mod 32. `rd_mask` returns physical word `rd_word` of core `rd_cpu`. `rd_pend` is that word ANDed with the matching `src_status` bits.
- R7: A command with `cmd_op`=0 (disable) clears source `cmd_src` in the enable bank of every present core. The change is visible on the read port after the next clock edge.
- R8: A command with `cmd_op`=1 (enable) sets source `cmd_src` for each core c for which `cpu_online[c]` is 1 and, when `cmd_aff_valid` is 1, `cmd_aff[c]` is 1. It clears that source for every other present core.
- R9: When `CASC_EN` is 1 and the granted source s lies in [`CASC_FIRST`, `CASC_LAST`], the block reports ID s-`CASC_FIRST` with `irq_ext`=1. Otherwise it reports ID s with `irq_ext`=0.
- R10: Once `irq_req[c]` is 1, it and the ID stay stable until a cycle with `irq_ack[c]`=1. The request then drops for at least one cycle.
- R11: With `NUM_SRC`=32, core 1 has no enable bank. Its reads return 0 and it never raises a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| src_status | input | NUM_SRC | Raw status of each source |
| cpu_online | input | 2 | Online flag per core |
| cmd_valid | input | 1 | Enable-bank command strobe |
| cmd_op | input | 1 | 0 = disable source, 1 = enable source |
| cmd_src | input | SRC_W | Source index the command acts on |
| cmd_aff_valid | input | 1 | Affinity set supplied with an enable command |
| cmd_aff | input | 2 | Affinity set, one bit per core |
| rd_cpu | input | 1 | Core whose bank is read |
| rd_word | input | WIDX_W | Physical word index to read |
| rd_mask | output | 32 | Enable word read back |
| rd_pend | output | 32 | Enable word ANDed with the matching status bits |
| irq_req | output | 2 | Request per core |
| irq_ack | input | 2 | Acknowledge per core |
| irq_id | output | 2*SRC_W | Reported ID per core, core c at bits [c*SRC_W +: SRC_W] |
| irq_ext | output | 2 | Reported ID belongs to the cascaded window |

## Verification
A stale or corrupted rotation pointer does not show up until the next grant. It then shows as a source ID out of rotation order, so the reference model compares ID, tag and request on every cycle rather than only at grant points. A wrong bit in an enable bank shows at once on the read port and, a cycle later, as a request that should or should not rise. A swapped word order shows on the first read of a source above 31. The bench idles with status gated off, then reopens the sources, to expose a pointer that drifts while nothing is pending.

// File: rtl/rrsel_pkg.sv
package rrsel_pkg;
  localparam int NUM_CPU   = 2;
  localparam int WORD_BITS = 32;

  typedef enum logic {
    OP_DISABLE = 1'b0,
    OP_ENABLE  = 1'b1
  } bank_op_e;
endpackage

// File: rtl/rrsel_mask_bank.sv
module rrsel_mask_bank
  import rrsel_pkg::*;
#(
  parameter int NUM_SRC = 64,
  localparam int WORDS  = NUM_SRC / WORD_BITS,
  localparam int SRC_W  = $clog2(NUM_SRC),
  localparam int WIDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cmd_valid,
  input  bank_op_e                          cmd_op,
  input  logic [SRC_W-1:0]                  cmd_src,
  input  logic                              cmd_aff_valid,
  input  logic [NUM_CPU-1:0]                cmd_aff,
  input  logic [NUM_CPU-1:0]                cpu_online,
  input  logic                              rd_cpu,
  input  logic [WIDX_W-1:0]                 rd_word,
  output logic [WORD_BITS-1:0]              rd_mask,
  output logic [NUM_CPU-1:0][NUM_SRC-1:0]   mask_flat
);
  // core 1 has a bank only when there is more than one word
  localparam bit SECOND_BANK = (WORDS > 1);

  logic [WORD_BITS-1:0] bank_q [NUM_CPU][WORDS];
  logic [WORD_BITS-1:0] bank_d [NUM_CPU][WORDS];
  logic [WIDX_W-1:0]    cmd_word;
  logic [4:0]           cmd_bit;

  always_comb begin
    cmd_bit  = cmd_src[4:0];
    cmd_word = WIDX_W'((int'(cmd_src) / WORD_BITS) ^ (WORDS - 1));
    bank_d   = bank_q;
    for (int c = 0; c < NUM_CPU; c++) begin
      if (c == 0 || SECOND_BANK) begin
        if (cmd_op == OP_ENABLE)
          bank_d[c][cmd_word][cmd_bit] = cpu_online[c] & (~cmd_aff_valid | cmd_aff[c]);
        else
          bank_d[c][cmd_word][cmd_bit] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CPU; c++)
        for (int w = 0; w < WORDS; w++)
          bank_q[c][w] <= '0;
    end else if (cmd_valid) begin
      for (int c = 0; c < NUM_CPU; c++)
        for (int w = 0; w < WORDS; w++)
          bank_q[c][w] <= bank_d[c][w];
    end
  end

  // logical source order seen by the arbiters
  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    for (genvar lw = 0; lw < WORDS; lw++) begin : g_word
      assign mask_flat[c][lw*WORD_BITS +: WORD_BITS] = bank_q[c][lw ^ (WORDS - 1)];
    end
  end

  always_comb begin
    rd_mask = '0;
    if ((int'(rd_word) < WORDS) && (!rd_cpu || SECOND_BANK))
      rd_mask = bank_q[rd_cpu][rd_word];
  end
endmodule

// File: rtl/rrsel_arbiter.sv
module rrsel_arbiter #(
  parameter int NUM_SRC = 64,
  localparam int SRC_W  = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] pend,
  input  logic               ack,
  output logic               req,
  output logic [SRC_W-1:0]   sel
);
  logic             req_q, req_d;
  logic [SRC_W-1:0] ptr_q, ptr_d;
  logic [SRC_W-1:0] sel_q, sel_d;
  logic [SRC_W-1:0] cand, hit_idx;
  logic             hit, state_en;

  // scan upward from the pointer, wrapping by index overflow
  always_comb begin
    hit     = 1'b0;
    hit_idx = ptr_q;
    cand    = ptr_q;
    for (int k = 0; k < NUM_SRC; k++) begin
      cand = ptr_q + SRC_W'(k);
      if (!hit && pend[cand]) begin
        hit     = 1'b1;
        hit_idx = cand;
      end
    end
  end

  always_comb begin
    req_d    = req_q;
    ptr_d    = ptr_q;
    sel_d    = sel_q;
    state_en = req_q ? ack : hit;
    if (req_q) begin
      if (ack) begin
        req_d = 1'b0;
        ptr_d = sel_q + 1'b1;
      end
    end else if (hit) begin
      req_d = 1'b1;
      sel_d = hit_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      ptr_q <= '0;
      sel_q <= '0;
    end else if (state_en) begin
      req_q <= req_d;
      ptr_q <= ptr_d;
      sel_q <= sel_d;
    end
  end

  assign req = req_q;
  assign sel = sel_q;
endmodule

// File: rtl/rr_irq_selector.sv
module rr_irq_selector
  import rrsel_pkg::*;
#(
  parameter int NUM_SRC    = 64,
  parameter bit CASC_EN    = 1'b1,
  parameter int CASC_FIRST = 40,
  parameter int CASC_LAST  = 45,
  localparam int WORDS     = NUM_SRC / WORD_BITS,
  localparam int SRC_W     = $clog2(NUM_SRC),
  localparam int WIDX_W    = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_SRC-1:0]       src_status,
  input  logic [NUM_CPU-1:0]       cpu_online,
  input  logic                     cmd_valid,
  input  logic                     cmd_op,
  input  logic [SRC_W-1:0]         cmd_src,
  input  logic                     cmd_aff_valid,
  input  logic [NUM_CPU-1:0]       cmd_aff,
  input  logic                     rd_cpu,
  input  logic [WIDX_W-1:0]        rd_word,
  output logic [WORD_BITS-1:0]     rd_mask,
  output logic [WORD_BITS-1:0]     rd_pend,
  output logic [NUM_CPU-1:0]       irq_req,
  input  logic [NUM_CPU-1:0]       irq_ack,
  output logic [NUM_CPU*SRC_W-1:0] irq_id,
  output logic [NUM_CPU-1:0]       irq_ext
);
  logic [1:0]                     rst_pipe;
  logic                           rst_int_n;
  logic [NUM_CPU-1:0][NUM_SRC-1:0] mask_flat;
  logic [WORD_BITS-1:0]           stat_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  rrsel_mask_bank #(.NUM_SRC(NUM_SRC)) u_bank (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .cmd_valid     (cmd_valid),
    .cmd_op        (bank_op_e'(cmd_op)),
    .cmd_src       (cmd_src),
    .cmd_aff_valid (cmd_aff_valid),
    .cmd_aff       (cmd_aff),
    .cpu_online    (cpu_online),
    .rd_cpu        (rd_cpu),
    .rd_word       (rd_word),
    .rd_mask       (rd_mask),
    .mask_flat     (mask_flat)
  );

  always_comb begin
    stat_word = '0;
    for (int w = 0; w < WORDS; w++)
      if (WIDX_W'(w ^ (WORDS - 1)) == rd_word)
        stat_word = src_status[w*WORD_BITS +: WORD_BITS];
  end
  assign rd_pend = rd_mask & stat_word;

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_core
    logic [SRC_W-1:0] sel;
    logic             req;
    logic             in_win;

    rrsel_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
      .clk   (clk),
      .rst_n (rst_int_n),
      .pend  (src_status & mask_flat[c]),
      .ack   (irq_ack[c]),
      .req   (req),
      .sel   (sel)
    );

    assign in_win = CASC_EN && (int'(sel) >= CASC_FIRST) && (int'(sel) <= CASC_LAST);
    assign irq_req[c] = req;
    assign irq_ext[c] = req & in_win;
    assign irq_id[c*SRC_W +: SRC_W] = !req   ? '0 :
                                      in_win ? (sel - SRC_W'(CASC_FIRST)) : sel;
  end
endmodule

// File: rtl/rr_irq_selector_chk.sv
module rr_irq_selector_chk #(
  parameter int NUM_SRC    = 64,
  parameter int CASC_FIRST = 40,
  parameter int CASC_LAST  = 45,
  localparam int SRC_W     = $clog2(NUM_SRC)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NUM_SRC-1:0]     src_status,
  input logic                   cmd_valid,
  input logic                   cmd_op,
  input logic [SRC_W-1:0]       cmd_src,
  input logic [1:0][NUM_SRC-1:0] mask_flat,
  input logic [1:0]             irq_req,
  input logic [1:0]             irq_ack,
  input logic [2*SRC_W-1:0]     irq_id,
  input logic [1:0]             irq_ext
);
  for (genvar c = 0; c < 2; c++) begin : g_c
    AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req[c] && !irq_ack[c] |=> irq_req[c] && $stable(irq_id[c*SRC_W +: SRC_W])); // R10
    AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req[c] && irq_ack[c] |=> !irq_req[c]); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_req[c] |-> (irq_id[c*SRC_W +: SRC_W] == '0) && !irq_ext[c]); // R5
    AST_EXT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ext[c] |-> int'(irq_id[c*SRC_W +: SRC_W]) <= (CASC_LAST - CASC_FIRST)); // R9
    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !cmd_op |=> !mask_flat[c][$past(cmd_src)]); // R7
    AST_REQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_req[c]) |-> $past(|(src_status & mask_flat[c]))); // R1
  end

  if (NUM_SRC == 32) begin : g_single
    AST_SECOND_CORE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_req[1] && (mask_flat[1] == '0)); // R11
  end
endmodule

bind rr_irq_selector rr_irq_selector_chk #(
  .NUM_SRC    (NUM_SRC),
  .CASC_FIRST (CASC_FIRST),
  .CASC_LAST  (CASC_LAST)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_int_n),
  .src_status (src_status),
  .cmd_valid  (cmd_valid),
  .cmd_op     (cmd_op),
  .cmd_src    (cmd_src),
  .mask_flat  (mask_flat),
  .irq_req    (irq_req),
  .irq_ack    (irq_ack),
  .irq_id     (irq_id),
  .irq_ext    (irq_ext)
);

// File: tb/rr_irq_selector_bench.sv
`timescale 1ns/1ps
module rr_irq_selector_bench;
  localparam int NS = 64;
  localparam int WF = 40;
  localparam int WL = 45;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] status;
  logic [1:0]  online;
  logic        cmd_valid, cmd_op, aff_v;
  logic [5:0]  cmd_src;
  logic [1:0]  aff;
  logic        rd_cpu;
  logic [0:0]  rd_word;
  logic [31:0] rd_mask, rd_pend;
  logic [1:0]  irq_req, irq_ack, irq_ext;
  logic [11:0] irq_id;

  // 32-source instance
  logic        s_cmd_valid, s_rd_cpu;
  logic [4:0]  s_cmd_src;
  logic [0:0]  s_rd_word;
  logic [31:0] s_rd_mask, s_rd_pend;
  logic [1:0]  s_req, s_ack, s_ext;
  logic [9:0]  s_id;

  int    checks = 0;
  int    errors = 0;
  bit    done   = 0;
  string cur_tag = "R5";

  bit m_mask [2][64];
  bit m_req  [2];
  int m_ptr  [2];
  int m_sel  [2];

  always #4 clk = ~clk;

  rr_irq_selector u_rr_irq_selector (
    .clk(clk), .rst_n(rst_n), .src_status(status), .cpu_online(online),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_src(cmd_src),
    .cmd_aff_valid(aff_v), .cmd_aff(aff), .rd_cpu(rd_cpu), .rd_word(rd_word),
    .rd_mask(rd_mask), .rd_pend(rd_pend), .irq_req(irq_req), .irq_ack(irq_ack),
    .irq_id(irq_id), .irq_ext(irq_ext));

  rr_irq_selector #(.NUM_SRC(32), .CASC_EN(1'b0), .CASC_FIRST(0), .CASC_LAST(0))
  u_rr_irq_selector_n32 (
    .clk(clk), .rst_n(rst_n), .src_status(32'hFFFF_FFFF), .cpu_online(2'b11),
    .cmd_valid(s_cmd_valid), .cmd_op(1'b1), .cmd_src(s_cmd_src),
    .cmd_aff_valid(1'b0), .cmd_aff(2'b00), .rd_cpu(s_rd_cpu), .rd_word(s_rd_word),
    .rd_mask(s_rd_mask), .rd_pend(s_rd_pend), .irq_req(s_req), .irq_ack(s_ack),
    .irq_id(s_id), .irq_ext(s_ext));

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_step();
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        m_req[c] = 0; m_ptr[c] = 0; m_sel[c] = 0;
        for (int s = 0; s < NS; s++) m_mask[c][s] = 0;
      end
      return;
    end
    for (int c = 0; c < 2; c++) begin
      if (m_req[c]) begin
        if (irq_ack[c]) begin
          m_req[c] = 0;
          m_ptr[c] = (m_sel[c] + 1) % NS;
        end
      end else begin
        for (int k = 0; k < NS; k++) begin
          int idx = (m_ptr[c] + k) % NS;
          if (!m_req[c] && status[idx] && m_mask[c][idx]) begin
            m_req[c] = 1;
            m_sel[c] = idx;
          end
        end
      end
    end
    if (cmd_valid)
      for (int c = 0; c < 2; c++)
        m_mask[c][cmd_src] = cmd_op ? (online[c] && (!aff_v || aff[c])) : 1'b0;
  endtask

  task automatic compare_all();
    logic [31:0] em, ep;
    for (int c = 0; c < 2; c++) begin
      bit win = m_req[c] && m_sel[c] >= WF && m_sel[c] <= WL;
      int eid = !m_req[c] ? 0 : (win ? m_sel[c] - WF : m_sel[c]);
      chk(cur_tag, $sformatf("req[%0d]", c), irq_req[c], m_req[c]);
      chk(cur_tag, $sformatf("id[%0d]", c), irq_id[c*6 +: 6], eid);
      chk(cur_tag, $sformatf("ext[%0d]", c), irq_ext[c], win);
    end
    for (int b = 0; b < 32; b++) begin
      int s = ((rd_word ^ 1) * 32) + b;
      em[b] = m_mask[rd_cpu][s];
      ep[b] = m_mask[rd_cpu][s] & status[s];
    end
    chk(cur_tag, "rd_mask", rd_mask, em);
    chk(cur_tag, "rd_pend", rd_pend, ep);
  endtask

  task automatic cycle();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic issue(input bit op, input int src, input bit av, input logic [1:0] af);
    cmd_valid = 1; cmd_op = op; cmd_src = 6'(src); aff_v = av; aff = af;
    cycle();
    cmd_valid = 0; aff_v = 0;
  endtask

  task automatic expect_grant(input int c, input int eid, input bit eext, input string tag);
    int n = 0;
    while (!irq_req[c] && n < 20) begin cycle(); n++; end
    chk(tag, "grant req", irq_req[c], 1);
    chk(tag, "grant id", irq_id[c*6 +: 6], eid);
    chk(tag, "grant ext", irq_ext[c], eext);
    irq_ack[c] = 1'b1;
    cycle();
    irq_ack[c] = 1'b0;
  endtask

  task automatic drain();
    repeat (10) begin
      irq_ack = irq_req;
      cycle();
    end
    irq_ack = '0;
  endtask

  task automatic read_bank(input bit cpu, input bit w, input logic [31:0] exp, input string tag);
    rd_cpu = cpu; rd_word = w;
    cycle();
    chk(tag, $sformatf("rd_mask cpu%0d word%0d", cpu, w), rd_mask, exp);
  endtask

  initial begin
    rst_n = 0; status = '1; online = 2'b11; cmd_valid = 0; cmd_op = 0; cmd_src = 0;
    aff_v = 0; aff = 0; rd_cpu = 0; rd_word = 0; irq_ack = 0;
    s_cmd_valid = 0; s_cmd_src = 0; s_rd_cpu = 0; s_rd_word = 0; s_ack = 0;
    repeat (3) cycle();
    chk("R5", "reset req", irq_req, 0);
    chk("R5", "reset id", irq_id, 0);
    @(negedge clk); rst_n = 1;
    repeat (4) cycle();
    chk("R5", "idle after reset", irq_req, 0);

    // R2 rotation, R3 wrap, R1 status gating, R4 independence, R6 layout
    cur_tag = "R2";
    issue(1, 3, 0, 0);
    issue(1, 10, 0, 0);
    issue(1, 50, 0, 0);
    read_bank(0, 1, (32'd1 << 3) | (32'd1 << 10), "R6");
    read_bank(0, 0, 32'd1 << 18, "R6");
    expect_grant(0, 3, 0, "R2");
    expect_grant(0, 10, 0, "R2");
    expect_grant(0, 50, 0, "R2");
    cur_tag = "R3";
    status[10] = 1'b0;
    expect_grant(0, 3, 0, "R3");
    cur_tag = "R1";
    expect_grant(0, 50, 0, "R1");
    status[10] = 1'b1;
    cur_tag = "R4";
    chk("R10", "core1 still holds", irq_id[6 +: 6], 3);
    expect_grant(1, 3, 0, "R4");
    expect_grant(1, 10, 0, "R4");

    // R7 disable in every bank, R5 idle
    cur_tag = "R7";
    issue(0, 3, 0, 0);
    issue(0, 10, 0, 0);
    issue(0, 50, 0, 0);
    drain();
    read_bank(1, 1, 32'd0, "R7");
    cur_tag = "R5";
    repeat (4) begin
      cycle();
      chk("R5", "no pending no req", irq_req, 0);
    end

    // R8 affinity, R9 cascade window
    cur_tag = "R8";
    issue(1, 42, 1, 2'b01);
    read_bank(0, 0, 32'd1 << 10, "R8");
    read_bank(1, 0, 32'd0, "R8");
    chk("R8", "core1 excluded no req", irq_req[1], 0);
    cur_tag = "R9";
    expect_grant(0, 2, 1, "R9");
    status = '0;
    issue(1, 45, 0, 0);
    issue(1, 46, 0, 0);
    issue(1, 40, 0, 0);
    cur_tag = "R5";
    repeat (5) begin
      cycle();
      chk("R5", "gated status no req", irq_req, 0);
    end
    status = '1;
    cur_tag = "R9";
    expect_grant(0, 5, 1, "R5");
    expect_grant(0, 46, 0, "R9");
    expect_grant(0, 0, 1, "R3");
    expect_grant(0, 2, 1, "R9");
    drain();

    // R8 online gating, R7 on both banks
    cur_tag = "R8";
    online = 2'b01;
    issue(1, 21, 0, 0);
    read_bank(1, 1, 32'd0, "R8");
    read_bank(0, 1, 32'd1 << 21, "R8");
    online = 2'b11;
    issue(1, 22, 0, 0);
    read_bank(1, 1, 32'd1 << 22, "R8");
    cur_tag = "R7";
    issue(0, 21, 0, 0);
    issue(0, 22, 0, 0);
    read_bank(0, 1, 32'd0, "R7");
    read_bank(1, 1, 32'd0, "R7");
    status[3] = 1'b0;
    issue(1, 3, 0, 0);
    read_bank(0, 1, 32'd1 << 3, "R6");
    chk("R6", "rd_pend gated", rd_pend, 0);
    status = '1;
    drain();

    // R11 on the 32-source instance
    cur_tag = "R11";
    s_cmd_src = 5; s_cmd_valid = 1;
    cycle();
    s_cmd_valid = 0;
    cycle();
    chk("R11", "core0 request", s_req[0], 1);
    chk("R11", "core0 id", s_id[4:0], 5);
    chk("R11", "core1 no request", s_req[1], 0);
    s_rd_cpu = 1;
    cycle();
    chk("R11", "core1 bank reads zero", s_rd_mask, 0);
    s_rd_cpu = 0;
    cycle();
    chk("R11", "core0 bank", s_rd_mask, 32'd1 << 5);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule